// File: doc/BRIEF.md
# Oversampling Serial Receiver with Receive Queue

This block turns an asynchronous serial line into bytes. Each frame has one low start bit, eight data bits sent least significant bit first, no parity, and one high stop bit. The line passes through a two-flop synchroniser. A tick generator driven by a 16-bit divisor produces sixteen sample ticks per bit period. Every bit is settled by a two-of-three vote taken at the middle of the bit. Bytes that arrive intact are placed in an eight-entry queue.

Software-facing logic reads the queue through a 32-bit data word. A one-cycle read strobe pops the oldest byte. The word carries the byte in its low eight bits and a flag in its top bit that is set when nothing was available. A three-bit threshold drives a watermark pending output. An interrupt output is that pending bit gated by an enable input. While the receive enable is low, the line is ignored.

Top module: `uart_os_rx`

## Requirements
- R1: After reset `rd_data` is 0x8000_0000, and `wm_pending` and `irq` are low.
- R2: A sample tick occurs once every `divisor`+1 clock cycles and sixteen ticks form one bit period. A frame of start bit, eight data bits sent LSB first, and stop bit is captured correctly for several divisor values.
- R3: Each bit is decided by the majority of the samples on ticks 7, 8 and 9 of its bit period. A disturbance that flips only one of those samples does not change the bit, and one that flips two of them does.
- R4: A falling edge whose start bit votes high is treated as noise. No byte is stored, and a following proper frame is received normally.
- R5: A frame whose stop bit votes low is discarded and never enters the queue.
- R6: While `rx_enable` is low, frames on the line are not received.
- R7: A one-cycle `rd_stb` pops the oldest byte, and the result appears on `rd_data` in the next cycle. Bytes come out in arrival order, and `rd_data` holds its value until the next strobe.
- R8: A strobe while the queue is empty returns bit 31 set and bits [7:0] zero, and leaves the queue untouched.
- R9: Bits [30:8] of `rd_data` are always zero, and bit 31 is clear whenever a byte is returned.
- R10: The queue holds eight bytes. A byte completed while it is full is dropped, and the eight stored bytes are kept.
- R11: `wm_pending` is high exactly when the queue count is strictly greater than `wm_thresh`, one cycle after either one changes.
- R12: `irq` equals `wm_pending` AND `irq_en`, and is registered with the same timing as `wm_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial line, idle high |
| rx_enable | input | 1 | Receive enable |
| divisor | input | 16 | Sample tick period minus one, in clock cycles |
| wm_thresh | input | 3 | Watermark threshold |
| irq_en | input | 1 | Interrupt enable |
| rd_stb | input | 1 | One-cycle read of the data word |
| rd_data | output | 32 | Data word: byte [7:0], zeros [30:8], empty flag [31] |
| wm_pending | output | 1 | Queue count above threshold |
| irq | output | 1 | Gated watermark interrupt |

## Verification
The assertions assume that `rd_stb` is the only thing that moves `rd_data`. They also assume that `irq_en` is sampled in the same way as the count, so a one-cycle lag is part of the contract. The bench drives `rd_stb` only as single-cycle pulses on falling clock edges and holds it low during reset, so the hold and gating properties are checked from the first cycle after reset. Serial frames are generated cycle by cycle at exactly sixteen ticks per bit. Disturbances are placed at least one and a half cycles away from each vote sample, so the vote properties are tested away from any ambiguous timing.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;

  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/uorx_sync.sv
module uorx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uorx_baud.sv
module uorx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == divisor) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uorx_frame.sv
module uorx_frame
  import uart_os_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              line,
  input  logic              tick,
  output logic              baud_restart,
  output logic              byte_vld,
  output logic [DATA_W-1:0] byte_data
);
  localparam int OSW = $clog2(OS);
  localparam int BW  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [OSW-1:0] V0   = OSW'(OS/2 - 1);
  localparam logic [OSW-1:0] V1   = OSW'(OS/2);
  localparam logic [OSW-1:0] V2   = OSW'(OS/2 + 1);
  localparam logic [OSW-1:0] VEND = OSW'(OS/2 + 2);
  localparam logic [OSW-1:0] LAST = OSW'(OS - 1);
  localparam logic [BW-1:0]  BLAST = BW'(DATA_W - 1);

  rx_state_t         state;
  logic [OSW-1:0]    os_cnt;
  logic [2:0]        votes;
  logic [BW-1:0]     bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              line_q;
  logic              fall;
  logic              maj;

  assign fall         = line_q & ~line;
  assign maj          = vote3(votes);
  assign baud_restart = (state == RX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b1;
    else     line_q <= line;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      os_cnt    <= '0;
      votes     <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (!en) begin
        state <= RX_IDLE;
      end else if (state == RX_IDLE) begin
        if (fall) begin
          state  <= RX_START;
          os_cnt <= '0;
        end
      end else if (tick) begin
        os_cnt <= os_cnt + 1'b1;
        if (os_cnt == V0) votes[0] <= line;
        if (os_cnt == V1) votes[1] <= line;
        if (os_cnt == V2) votes[2] <= line;
        case (state)
          RX_START: if (os_cnt == LAST) begin
            if (maj) state <= RX_IDLE;
            else begin
              state   <= RX_DATA;
              bit_idx <= '0;
            end
          end
          RX_DATA: if (os_cnt == LAST) begin
            shreg <= {maj, shreg[DATA_W-1:1]};
            if (bit_idx == BLAST) state <= RX_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end
          RX_STOP: if (os_cnt == VEND) begin
            state <= RX_IDLE;
            if (maj) begin
              byte_vld  <= 1'b1;
              byte_data <= shreg;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uorx_fifo.sv
module uorx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          pop_ok,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, empty, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (do_pop) pop_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      rp     <= '0;
      count  <= '0;
      pop_ok <= 1'b0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (pop)     pop_ok <= do_pop;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int DIV_W   = 16,
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 8,
  parameter int TH_W    = 3,
  parameter int OS      = 16,
  parameter int SYNC_ST = 2,
  parameter int WORD_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  input  logic              rx_enable,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [TH_W-1:0]   wm_thresh,
  input  logic              irq_en,
  input  logic              rd_stb,
  output logic [WORD_W-1:0] rd_data,
  output logic              wm_pending,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic              line_s, tick, restart, bvld, pop_ok, wm_cond;
  logic [DATA_W-1:0] bdata, pop_data;
  logic [CW-1:0]     count;

  uorx_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst(rst), .d(rxd), .q(line_s)
  );

  uorx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .restart(restart), .divisor(divisor), .tick(tick)
  );

  uorx_frame #(.DATA_W(DATA_W), .OS(OS)) u_frame (
    .clk(clk), .rst(rst), .en(rx_enable), .line(line_s), .tick(tick),
    .baud_restart(restart), .byte_vld(bvld), .byte_data(bdata)
  );

  uorx_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(bvld), .push_data(bdata), .pop(rd_stb),
    .pop_ok(pop_ok), .pop_data(pop_data), .count(count)
  );

  assign wm_cond = (int'(count) > int'(wm_thresh));

  always_ff @(posedge clk) begin
    if (rst) begin
      wm_pending <= 1'b0;
      irq        <= 1'b0;
    end else begin
      wm_pending <= wm_cond;
      irq        <= wm_cond & irq_en;
    end
  end

  always_comb begin
    rd_data             = '0;
    rd_data[WORD_W-1]   = ~pop_ok;
    rd_data[DATA_W-1:0] = pop_ok ? pop_data : '0;
  end
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int WORD_W = 32,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_stb,
  input logic              irq_en,
  input logic [WORD_W-1:0] rd_data,
  input logic              wm_pending,
  input logic              irq
);
  AST_WORD_ZEROS: assert property (@(posedge clk) disable iff (rst)
    rd_data[WORD_W-2:DATA_W] == '0);  // R9
  AST_EMPTY_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_data[WORD_W-1] |-> (rd_data[DATA_W-1:0] == '0));  // R8
  AST_HOLD_WITHOUT_READ: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_stb) |-> $stable(rd_data));  // R7
  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    irq |-> wm_pending);  // R12
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en));  // R12
endmodule

bind uart_os_rx uart_os_rx_chk #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rd_stb(rd_stb), .irq_en(irq_en),
  .rd_data(rd_data), .wm_pending(wm_pending), .irq(irq)
);

// File: tb/uart_os_rx_bench.sv
module uart_os_rx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rxd = 1'b1;
  logic        rx_enable = 1'b0;
  logic [15:0] divisor = 16'd3;
  logic [2:0]  wm_thresh = 3'd0;
  logic        irq_en = 1'b0;
  logic        rd_stb = 1'b0;
  logic [31:0] rd_data;
  logic        wm_pending, irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_os_rx u_uart_os_rx (
    .clk(clk), .rst(rst), .rxd(rxd), .rx_enable(rx_enable),
    .divisor(divisor), .wm_thresh(wm_thresh), .irq_en(irq_en),
    .rd_stb(rd_stb), .rd_data(rd_data), .wm_pending(wm_pending), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Send one frame; bit gb (0=start,1..8 data,9=stop) is inverted for cycles [gs, gs+gl)
  task automatic send(input logic [7:0] b, input logic stopv,
                      input int gb, input int gs, input int gl);
    int bc;
    logic [9:0] fr;
    bc = 16 * (int'(divisor) + 1);
    fr = {stopv, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      for (int c = 0; c < bc; c++) begin
        @(negedge clk);
        rxd = (k == gb && c >= gs && c < gs + gl) ? ~fr[k] : fr[k];
      end
    end
    @(negedge clk);
    rxd = 1'b1;
    idle(bc);
  endtask

  task automatic read_word(output logic [31:0] w);
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    w = rd_data;
  endtask

  task automatic expect_byte(input string req, input logic [7:0] b);
    logic [31:0] w;
    read_word(w);
    check(req, w, {24'h0, b});
  endtask

  task automatic expect_empty(input string req);
    logic [31:0] w;
    read_word(w);
    check(req, w, 32'h8000_0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 rd_data", rd_data, 32'h8000_0000);
    check("R1 wm_pending", {31'h0, wm_pending}, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // R6 disabled receiver ignores the line
    send(8'h5A, 1'b1, -1, 0, 0);
    expect_empty("R6 frame while disabled");
    rx_enable = 1'b1;
    idle(4);

    // R2 several patterns and divisors
    begin
      logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'h55, 8'h3C};
      for (int i = 0; i < 4; i++) begin
        send(pats[i], 1'b1, -1, 0, 0);
        expect_byte("R2 pattern", pats[i]);
      end
    end
    divisor = 16'd0; idle(4);
    send(8'h96, 1'b1, -1, 0, 0);
    expect_byte("R2 divisor 0", 8'h96);
    divisor = 16'd10; idle(4);
    send(8'h69, 1'b1, -1, 0, 0);
    expect_byte("R2 divisor 10", 8'h69);
    divisor = 16'd3; idle(4);

    // R3 vote samples sit near cycles 33.5, 37.5, 41.5 of a 64-cycle bit
    send(8'hA5, 1'b1, 3, 36, 3);
    expect_byte("R3 one sample flipped", 8'hA5);
    send(8'hA5, 1'b1, 3, 32, 7);
    expect_byte("R3 two samples flipped", 8'hA1);
    send(8'hA5, 1'b1, 3, 0, 20);
    expect_byte("R3 edge of bit disturbed", 8'hA5);

    // R4 false start
    @(negedge clk); rxd = 1'b0;
    idle(8);
    @(negedge clk); rxd = 1'b1;
    idle(160);
    expect_empty("R4 glitch start no byte");
    send(8'hC3, 1'b1, -1, 0, 0);
    expect_byte("R4 frame after glitch", 8'hC3);

    // R5 bad stop bit
    send(8'h7E, 1'b0, -1, 0, 0);
    idle(64);
    expect_empty("R5 low stop dropped");

    // R7 hold without strobe
    send(8'h42, 1'b1, -1, 0, 0);
    read_word(w);
    check("R7 read", w, 32'h0000_0042);
    idle(20);
    check("R7 hold", rd_data, 32'h0000_0042);

    // R10 fill nine, R11/R12 sweep, R7 order
    for (int i = 0; i < 9; i++) send(8'(i * 17 + 3), 1'b1, -1, 0, 0);
    for (int cnt = 8; cnt >= 0; cnt--) begin
      for (int th = 0; th < 8; th++) begin
        @(negedge clk);
        wm_thresh = 3'(th);
        irq_en = th[0];
        idle(3);
        check("R11 watermark", {31'h0, wm_pending}, {31'h0, cnt > th});
        check("R12 irq", {31'h0, irq}, {31'h0, (cnt > th) && th[0]});
      end
      if (cnt > 0) expect_byte("R10 R7 queued byte", 8'((8 - cnt) * 17 + 3));
    end
    irq_en = 1'b0;

    // R8 empty reads leave pointers alone
    expect_empty("R8 empty read 1");
    expect_empty("R8 empty read 2");
    send(8'hE1, 1'b1, -1, 0, 0);
    send(8'h1E, 1'b1, -1, 0, 0);
    expect_byte("R8 after empty reads", 8'hE1);
    expect_byte("R9 second byte word", 8'h1E);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule